// File: doc/BRIEF.md
# Non-Retriggerable Digital One-Shot

A clocked pulse generator that produces one output pulse of a programmable length each time a qualified trigger occurs. Three inputs can start a pulse: an active-low trigger input, an active-high trigger input and an active-low clear. Each one counts only when the other two are at their enabling levels. All three inputs are asynchronous. Each one passes through a two-flop synchronizer, and edges are found by comparing the synchronized sample with the one from the previous cycle.

When a trigger is accepted, the output rises on the next cycle for a number of cycles given by the `width` input. `width` is sampled when the trigger is accepted, and zero counts as one cycle. While a pulse runs, the block does not restart or extend it. A low level on clear ends a running pulse at once. While clear stays low, no trigger is accepted. A clear that cuts a pulse short starts a fixed recovery interval, and the block ignores every trigger until that interval ends.

Top module: `oneshot_pulse`

## Requirements
- R1: A falling edge on `trig_a_n` starts a pulse only if `trig_b` is 1 and `clear_n` is 1 in the cycle the edge is seen. If either is 0, the edge has no effect on `q`.
- R2: A rising edge on `trig_b` starts a pulse only if `trig_a_n` is 0 and `clear_n` is 1 in the cycle the edge is seen. If either condition fails, the edge has no effect on `q`.
- R3: A rising edge on `clear_n` starts a pulse only if `trig_a_n` is 0 and `trig_b` is 1 in the cycle the edge is seen. If either condition fails, the edge has no effect on `q`.
- R4: Each input passes through two synchronizer flops. Suppose an input changes just after rising edge k and makes a trigger valid. Then `q` is first high after rising edge k+3, whatever the value of `width`.
- R5: `q` stays high for exactly max(`width`,1) cycles. `width` is sampled in the cycle the trigger is accepted, and later changes to `width` do not affect the running pulse.
- R6: The block ignores a qualified edge on `trig_a_n` or `trig_b` that is seen while a pulse runs, including the pulse's last high cycle. Such an edge neither restarts nor extends the pulse. A qualified edge seen in the first cycle after the pulse ends starts a new pulse.
- R7: If the synchronized `clear_n` is 0 during a pulse, `q` is 0 in that same cycle. This is the second rising edge after `clear_n` falls.
- R8: While the synchronized `clear_n` is 0, no trigger is accepted and `q` stays 0.
- R9: After a clear cuts a pulse short, the block ignores every trigger for 4 cycles (parameter `REC_CYCLES`), counted from the cycle after the cut. This includes a rising edge on `clear_n`. A trigger seen after those 4 cycles is accepted.
- R10: `q_n` is always the inverse of `q`.
- R11: Synchronous reset (`rst` = 1) puts the block in its idle state with `q` = 0 and `q_n` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_a_n | input | 1 | Asynchronous trigger, active on its falling edge |
| trig_b | input | 1 | Asynchronous trigger, active on its rising edge |
| clear_n | input | 1 | Asynchronous active-low clear; its rising edge can also trigger |
| width | input | WIDTH_W | Pulse length in cycles, sampled when a trigger is accepted |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Inverse of `q` |

## Verification
Two functions can fall on the same cycle. The first pair is a pulse finishing and a new qualified edge arriving. The bench places a falling edge on the active-low trigger in the pulse's last high cycle, then one cycle later. The first must leave `q` low after the pulse. The second must give exactly one low cycle followed by a full new pulse. The second pair is the end of recovery and a new trigger. The bench places an edge on the active-high trigger in the last recovery cycle and in the first idle cycle, and expects only the second to start a pulse. It also releases clear while recovery is still running, with both other inputs enabling, and expects no pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Controller phases of the one-shot
    typedef enum logic [1:0] {
        OS_IDLE    = 2'd0,
        OS_PULSE   = 2'd1,
        OS_RECOVER = 2'd2
    } os_state_e;

    // Bit positions of the three inputs inside the synchronized bundle
    localparam int unsigned IN_A_N  = 0;
    localparam int unsigned IN_B    = 1;
    localparam int unsigned IN_CLRN = 2;
    localparam int unsigned IN_CNT  = 3;

    // Idle levels: active-low trigger high, active-high trigger low, clear released
    localparam logic [IN_CNT-1:0] IN_IDLE = 3'b101;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int unsigned          N         = 3,
    parameter int unsigned          STAGES    = 2,
    parameter logic [N-1:0]         RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [STAGES-1:0][N-1:0] stage_d;
    logic [STAGES-1:0][N-1:0] stage_q;

    assign stage_d[0] = din;

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_chain
            assign stage_d[g] = stage_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= {STAGES{RESET_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/oneshot_edge_qual.sv
module oneshot_edge_qual
    import oneshot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_CNT-1:0] cur,
    output logic              trig_hit
);

    logic [IN_CNT-1:0] prev_d;
    logic [IN_CNT-1:0] prev_q;

    logic a_fall;
    logic b_rise;
    logic c_rise;

    always_comb begin
        prev_d = cur;
        // Each edge is qualified by the present levels of the other two inputs
        a_fall =  prev_q[IN_A_N]  & ~cur[IN_A_N]
               &  cur[IN_B]       &  cur[IN_CLRN];
        b_rise = ~prev_q[IN_B]    &  cur[IN_B]
               & ~cur[IN_A_N]     &  cur[IN_CLRN];
        c_rise = ~prev_q[IN_CLRN] &  cur[IN_CLRN]
               & ~cur[IN_A_N]     &  cur[IN_B];
        trig_hit = a_fall | b_rise | c_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= IN_IDLE;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/oneshot_down_cnt.sv
module oneshot_down_cnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
    import oneshot_pkg::*;
#(
    parameter int unsigned WIDTH_W     = 16,
    parameter int unsigned REC_CYCLES  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_a_n,
    input  logic               trig_b,
    input  logic               clear_n,
    input  logic [WIDTH_W-1:0] width,
    output logic               q,
    output logic               q_n
);

    localparam int unsigned REC_W = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
    localparam logic [REC_W-1:0] REC_LOAD = REC_W'(REC_CYCLES - 1);

    logic [IN_CNT-1:0] raw_in;
    logic [IN_CNT-1:0] sync_in;
    logic              clr_s;
    logic              trig_hit;
    logic              trig_take;
    logic              in_pulse;
    logic              in_recover;

    logic               p_load;
    logic               p_dec;
    logic               p_zero;
    logic [WIDTH_W-1:0] p_val;
    logic               r_load;
    logic               r_dec;
    logic               r_zero;

    os_state_e state_d;
    os_state_e state_q;

    always_comb begin
        raw_in          = '0;
        raw_in[IN_A_N]  = trig_a_n;
        raw_in[IN_B]    = trig_b;
        raw_in[IN_CLRN] = clear_n;
    end

    oneshot_sync #(
        .N         (IN_CNT),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (IN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_in)
    );

    oneshot_edge_qual u_qual (
        .clk      (clk),
        .rst      (rst),
        .cur      (sync_in),
        .trig_hit (trig_hit)
    );

    assign clr_s      = sync_in[IN_CLRN];
    assign in_pulse   = (state_q == OS_PULSE);
    assign in_recover = (state_q == OS_RECOVER);
    assign p_val      = (width == '0) ? '0 : (width - 1'b1);

    oneshot_down_cnt #(.W(WIDTH_W)) u_pulse_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (p_load),
        .load_val (p_val),
        .dec      (p_dec),
        .zero     (p_zero)
    );

    oneshot_down_cnt #(.W(REC_W)) u_rec_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (r_load),
        .load_val (REC_LOAD),
        .dec      (r_dec),
        .zero     (r_zero)
    );

    always_comb begin
        state_d   = state_q;
        trig_take = 1'b0;
        p_load    = 1'b0;
        p_dec     = 1'b0;
        r_load    = 1'b0;
        r_dec     = 1'b0;
        unique case (state_q)
            OS_IDLE: begin
                if (trig_hit) begin
                    trig_take = 1'b1;
                    p_load    = 1'b1;
                    state_d   = OS_PULSE;
                end
            end
            OS_PULSE: begin
                // Trigger edges are not looked at here: non-retriggerable
                if (!clr_s) begin
                    r_load  = 1'b1;
                    state_d = OS_RECOVER;
                end else if (p_zero) begin
                    state_d = OS_IDLE;
                end else begin
                    p_dec = 1'b1;
                end
            end
            OS_RECOVER: begin
                if (in_recover && r_zero) begin
                    state_d = OS_IDLE;
                end else begin
                    r_dec = 1'b1;
                end
            end
            default: state_d = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // A synchronized low clear drops the output in the same cycle
    assign q   = in_pulse & clr_s;
    assign q_n = ~q;

endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
    parameter int unsigned WIDTH_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               q,
    input logic               q_n,
    input logic [WIDTH_W-1:0] width,
    input logic               clr_s,
    input logic               trig_take,
    input logic               in_pulse,
    input logic               in_recover
);

    logic [WIDTH_W:0] wexp_q;
    logic [WIDTH_W:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wexp_q <= '0;
            run_q  <= '0;
        end else begin
            if (trig_take) begin
                wexp_q <= (width == '0) ? (WIDTH_W+1)'(1) : {1'b0, width};
            end
            run_q <= q ? (run_q + 1'b1) : '0;
        end
    end

    // R10
    qn_complement_chk: assert property (@(posedge clk) disable iff (rst)
        q_n == ~q);

    // R4
    q_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> $past(trig_take));

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(q) && clr_s) |-> (run_q == wexp_q));

    // R7
    clear_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (in_pulse && !clr_s) |=> in_recover);

    // R8
    clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_s |=> !q);

    // R9
    recover_block_chk: assert property (@(posedge clk) disable iff (rst)
        in_recover |=> !in_pulse);

endmodule

bind oneshot_pulse oneshot_pulse_chk #(.WIDTH_W(WIDTH_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .q          (q),
    .q_n        (q_n),
    .width      (width),
    .clr_s      (clr_s),
    .trig_take  (trig_take),
    .in_pulse   (in_pulse),
    .in_recover (in_recover)
);

// File: tb/oneshot_pulse_test.sv
module oneshot_pulse_test;

    logic        clk;
    logic        rst;
    logic        a_n;
    logic        b;
    logic        clr_n;
    logic [15:0] width;
    logic        q;
    logic        q_n;

    int checks = 0;
    int errors = 0;

    oneshot_pulse uut (
        .clk      (clk),
        .rst      (rst),
        .trig_a_n (a_n),
        .trig_b   (b),
        .clear_n  (clr_n),
        .width    (width),
        .q        (q),
        .q_n      (q_n)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung, expected finish");
        report();
    end

    task automatic chk(string tag, logic got, logic exp, int idx);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s step %0d: actual %b expected %b", tag, idx, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Input changes scheduled per scenario, applied right after sampling at step i
    task automatic drive(int scn, int i);
        case (scn)
            0: if (i == 3) width = width + 16'd7;              // R5 late change
            1: begin
                if (i == 1) a_n = 1'b1;
                if (i == 3) a_n = 1'b0;
                if (i == 4) b   = 1'b0;
                if (i == 5) b   = 1'b1;
                if (i == 6) a_n = 1'b1;
                if (i == 8) a_n = 1'b0;                        // last high cycle
            end
            2: begin
                if (i == 1) a_n = 1'b1;
                if (i == 3) a_n = 1'b0;
                if (i == 4) b   = 1'b0;
                if (i == 5) b   = 1'b1;
                if (i == 6) a_n = 1'b1;
                if (i == 9) a_n = 1'b0;                        // first idle cycle
            end
            3: begin
                if (i == 5)  clr_n = 1'b0;
                if (i == 9)  a_n   = 1'b1;
                if (i == 11) a_n   = 1'b0;
                if (i == 12) b     = 1'b0;
                if (i == 14) b     = 1'b1;
                if (i == 20) clr_n = 1'b1;
            end
            4: begin
                if (i == 5) clr_n = 1'b0;
                if (i == 6) clr_n = 1'b1;
            end
            5, 6: begin
                if (i == 4) b     = 1'b0;
                if (i == 5) clr_n = 1'b0;
                if (i == 6) clr_n = 1'b1;
                if (scn == 5 && i == 9)  b = 1'b1;             // last recovery cycle
                if (scn == 6 && i == 10) b = 1'b1;             // first idle cycle
            end
            default: ;
        endcase
    endtask

    // Sample q for len steps; expected high in [s1,e1) or [s2,e2)
    task automatic play(int scn, int len, int s1, int e1, int s2, int e2, string tag);
        for (int i = 1; i <= len; i++) begin
            logic exp;
            step();
            exp = ((i >= s1) && (i < e1)) || ((i >= s2) && (i < e2));
            chk(tag, q, exp, i);
            chk("R10", q_n, ~exp, i);
            drive(scn, i);
        end
    endtask

    task automatic settle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        rst   = 1'b1;
        a_n   = 1'b1;
        b     = 1'b0;
        clr_n = 1'b1;
        width = 16'd0;
        repeat (5) @(posedge clk);
        step();
        rst = 1'b0;
        step();
        // R11: idle after reset
        chk("R11", q, 1'b0, 0);
        chk("R11", q_n, 1'b1, 0);

        // R1 R2 R3 R4 R5: sweep trigger kinds and widths
        for (int wi = 0; wi < 7; wi++) begin
            int w;
            int wm;
            w  = (wi < 5) ? wi : ((wi == 5) ? 7 : 12);
            wm = (w == 0) ? 1 : w;
            for (int k = 0; k < 3; k++) begin
                width = 16'(w);
                if (k == 0) begin a_n = 1'b1; b = 1'b1; clr_n = 1'b1; end
                if (k == 1) begin a_n = 1'b0; b = 1'b0; clr_n = 1'b1; end
                if (k == 2) begin a_n = 1'b0; b = 1'b1; clr_n = 1'b0; end
                settle(6);
                if (k == 0) a_n   = 1'b0;
                if (k == 1) b     = 1'b1;
                if (k == 2) clr_n = 1'b1;
                play(0, 2 + wm + 5, 3, 3 + wm, 0, 0,
                     (k == 0) ? "R1/R4/R5" : ((k == 1) ? "R2/R4/R5" : "R3/R4/R5"));
            end
        end

        // R1 R2 R3 R8: edges whose qualifying levels are wrong
        a_n = 1'b1; b = 1'b0; clr_n = 1'b1;
        settle(6);
        a_n = 1'b0;                                   // B low
        play(7, 6, 0, 0, 0, 0, "R1");
        a_n = 1'b1;
        settle(4);
        b = 1'b1;                                     // A high
        play(7, 6, 0, 0, 0, 0, "R2");
        b = 1'b0; a_n = 1'b0;
        settle(4);
        clr_n = 1'b0;
        settle(4);
        clr_n = 1'b1;                                 // B low
        play(7, 6, 0, 0, 0, 0, "R3");
        a_n = 1'b1; b = 1'b1; clr_n = 1'b0;
        settle(4);
        a_n = 1'b0;                                   // clear held low
        play(7, 6, 0, 0, 0, 0, "R8");
        b = 1'b0;
        settle(4);
        clr_n = 1'b1;
        settle(4);

        // R6: ignored in pulse and on its last cycle
        width = 16'd8; a_n = 1'b0; b = 1'b0; clr_n = 1'b1;
        settle(6);
        b = 1'b1;
        play(1, 18, 3, 11, 0, 0, "R6");

        // R6: accepted on the first idle cycle
        width = 16'd8; a_n = 1'b0; b = 1'b0; clr_n = 1'b1;
        settle(6);
        b = 1'b1;
        play(2, 24, 3, 11, 12, 20, "R6");

        // R7 R8 R3: cut, hold low with edges, release after recovery
        width = 16'd20; a_n = 1'b1; b = 1'b1; clr_n = 1'b1;
        settle(6);
        a_n = 1'b0;
        play(3, 46, 3, 7, 23, 43, "R7/R8/R3");

        // R9: release of clear inside recovery is ignored
        width = 16'd20; a_n = 1'b1; b = 1'b1; clr_n = 1'b1;
        settle(6);
        a_n = 1'b0;
        play(4, 20, 3, 7, 0, 0, "R9");

        // R9: trigger in last recovery cycle ignored
        width = 16'd20; a_n = 1'b1; b = 1'b1; clr_n = 1'b1;
        settle(6);
        a_n = 1'b0;
        play(5, 26, 3, 7, 0, 0, "R9");

        // R9: trigger in first idle cycle after recovery accepted
        width = 16'd20; a_n = 1'b1; b = 1'b1; clr_n = 1'b1;
        settle(6);
        a_n = 1'b0;
        play(6, 36, 3, 7, 13, 33, "R9");

        report();
    end

endmodule